// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine moves frames from memory to a byte stream. Software builds a circular list of transmit descriptors in a small descriptor store. Each descriptor names a buffer start, a byte count and a set of flags. Frame bytes go into a separate byte-wide buffer store. The engine walks the list from a programmable base slot. For each descriptor that software has marked ready, it streams the bytes out with start and end markers under valid/ready flow control. It then clears the ready mark to give the slot back and pulses a completion strobe.

The engine comes out of reset parked, and it starts fetching only when software issues a clear-halt command. It parks again when it meets a slot that is not ready. A graceful-stop request lets the frame in flight finish, parks the engine, and raises a sticky completion event. The CRC-append and interrupt flags of the frame being sent are passed out as sideband signals for downstream logic. No CRC is computed and no interrupt is raised here.

Top module: `txbd_ring_engine`

## Requirements
- R1: After reset the engine is parked. The event register (address 2) reads bit 0 (parked) = 1 and bit 1 (stop-complete) = 0. `tx_valid` and `tx_done` are 0, and the current slot is 0.
- R2: While parked, the engine ignores ready descriptors and emits nothing. It leaves parking only on a write to the control register (address 1) with bit 0 set, which acts as a one-shot clear-halt command.
- R3: A descriptor word holds the buffer start in bits [7:0], the byte count in [15:8], ready in [16], wrap in [17], last in [18], CRC-append in [19] and interrupt in [20]. A ready descriptor produces exactly count bytes. Byte k equals buffer store location (start + k) mod 256. A byte held while `tx_ready` is low stays unchanged until it is accepted.
- R4: `tx_sof` is high on byte 0 only, and `tx_eof` is high on byte count-1 only. A one-byte descriptor has both markers on its single byte.
- R5: While a byte is valid, `tx_crc` and `tx_irq` equal the CRC-append and interrupt flags of the descriptor being sent.
- R6: When a descriptor completes, its ready bit reads back 0 and `tx_done` is high for exactly one cycle. A descriptor with count 0 completes this way without emitting any byte.
- R7: After a descriptor with wrap set, the next slot fetched is the ring base. Otherwise the next slot is the following one, modulo the number of slots.
- R8: On reaching a descriptor whose ready bit is 0, the engine parks and sets the parked bit. The next clear-halt command resumes at that same slot.
- R9: When the control register bit 1 (stop request) is 1 at a fetch, the engine parks instead of fetching and sets stop-complete. A frame already in flight always finishes first. Writing 1 to event bit 1 clears stop-complete.
- R10: A write to the base register (address 0) sets both the ring base and the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 base, 1 control, 2 event |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| desc_we | input | 1 | Descriptor store write strobe |
| desc_idx | input | 3 | Descriptor slot for software read and write |
| desc_wdata | input | 21 | Descriptor write word |
| desc_rdata | output | 21 | Descriptor word at `desc_idx` |
| buf_we | input | 1 | Buffer store write strobe |
| buf_addr | input | 8 | Buffer store write address |
| buf_wdata | input | 8 | Buffer store write byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First byte of a descriptor |
| tx_eof | output | 1 | Last byte of a descriptor |
| tx_crc | output | 1 | CRC-append flag of the current descriptor |
| tx_irq | output | 1 | Interrupt flag of the current descriptor |
| tx_done | output | 1 | One-cycle descriptor completion pulse |

## Verification
The case that needs care is a graceful-stop request written in the very cycle that the last byte of a frame is accepted. In that cycle, completing the frame and latching the stop request happen together. The bench holds `tx_ready` low until the one-byte frame shows its end marker. It then raises `tx_ready` and writes the stop request at the same falling edge. The run passes if that frame goes out whole and its slot is returned, the next slot, which is queued and ready, is left untouched, and the engine ends parked with stop-complete set.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int FLAG_N   = 5;
  localparam int FL_READY = 0;
  localparam int FL_WRAP  = 1;
  localparam int FL_LAST  = 2;
  localparam int FL_CRC   = 3;
  localparam int FL_IRQ   = 4;

  localparam logic [1:0] RA_BASE  = 2'd0;
  localparam logic [1:0] RA_CTRL  = 2'd1;
  localparam logic [1:0] RA_EVENT = 2'd2;

  typedef enum logic [1:0] {S_HALT, S_FETCH, S_SEND, S_RETIRE} seq_state_e;
endpackage

// File: rtl/txr_desc_ram.sv
module txr_desc_ram #(
  parameter int NUM_DESC = 8,
  parameter int DW       = 21,
  parameter int RDY_POS  = 16,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic             eng_clr,
  output logic [DW-1:0]    eng_rdata
);
  logic [NUM_DESC-1:0][DW-1:0] words;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
    logic [DW-1:0] word_q;
    logic          hit_host, hit_eng;
    assign hit_host = host_we && (host_idx == IDX_W'(g));
    assign hit_eng  = eng_clr && (eng_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (hit_host)     word_q <= host_wdata;
      else if (hit_eng) word_q[RDY_POS] <= 1'b0;
    end
    assign words[g] = word_q;
  end

  assign host_rdata = words[host_idx];
  assign eng_rdata  = words[eng_idx];
endmodule

// File: rtl/txr_buf_ram.sv
module txr_buf_ram #(
  parameter int AW     = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_wdata;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/txr_regs.sv
module txr_regs import txr_pkg::*; #(
  parameter int IDX_W = 3,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             halted,
  input  logic             gs_set,
  output logic [IDX_W-1:0] base_idx,
  output logic             load_en,
  output logic [IDX_W-1:0] load_idx,
  output logic             clr_halt,
  output logic             gs_req,
  output logic             gs_done
);
  logic [IDX_W-1:0] base_q, base_d;
  logic             gs_req_q, gs_req_d, gs_done_q, gs_done_d;
  logic             wr_ctrl, wr_evt;

  always_comb begin
    load_en  = reg_wr && (reg_addr == RA_BASE);
    wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
    wr_evt   = reg_wr && (reg_addr == RA_EVENT);
    load_idx = reg_wdata[IDX_W-1:0];
    clr_halt = wr_ctrl && reg_wdata[0];
    base_d   = load_idx;
    gs_req_d = wr_ctrl ? reg_wdata[1] : gs_req_q;
    if (gs_set)                      gs_done_d = 1'b1;
    else if (wr_evt && reg_wdata[1]) gs_done_d = 1'b0;
    else                             gs_done_d = gs_done_q;
    reg_rdata = '0;
    case (reg_addr)
      RA_BASE:  reg_rdata[IDX_W-1:0] = base_q;
      RA_CTRL:  reg_rdata[1] = gs_req_q;
      RA_EVENT: reg_rdata[1:0] = {gs_done_q, halted};
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      gs_req_q  <= 1'b0;
      gs_done_q <= 1'b0;
    end else begin
      if (load_en) base_q <= base_d;
      gs_req_q  <= gs_req_d;
      gs_done_q <= gs_done_d;
    end
  end

  assign base_idx = base_q;
  assign gs_req   = gs_req_q;
  assign gs_done  = gs_done_q;
endmodule

// File: rtl/txr_seq.sv
module txr_seq import txr_pkg::*; #(
  parameter int NUM_DESC = 8,
  parameter int PTR_W    = 8,
  parameter int LEN_W    = 8,
  parameter int IDX_W    = 3,
  localparam int DW      = FLAG_N + LEN_W + PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_halt,
  input  logic             gs_req,
  input  logic [IDX_W-1:0] base_idx,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [DW-1:0]    desc_word,
  output logic [IDX_W-1:0] desc_idx,
  output logic             desc_clr,
  output logic [PTR_W-1:0] buf_addr,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             tx_sof,
  output logic             tx_eof,
  output logic             tx_crc,
  output logic             tx_irq,
  output logic             tx_done,
  output logic             halted,
  output logic             gs_set
);
  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  cur_q, cur_d, nxt_idx;
  logic [LEN_W-1:0]  cnt_q, cnt_d, len_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              crc_q, irq_q, wrap_q, ld_en, last_byte;
  logic [PTR_W-1:0]  d_ptr;
  logic [LEN_W-1:0]  d_len;
  logic [FLAG_N-1:0] d_flags;

  assign d_ptr     = desc_word[PTR_W-1:0];
  assign d_len     = desc_word[PTR_W +: LEN_W];
  assign d_flags   = desc_word[PTR_W+LEN_W +: FLAG_N];
  assign last_byte = (cnt_q == len_q - LEN_W'(1));
  assign nxt_idx   = (cur_q == IDX_W'(NUM_DESC-1)) ? '0 : cur_q + IDX_W'(1);

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    cnt_d    = cnt_q;
    ld_en    = 1'b0;
    desc_clr = 1'b0;
    tx_done  = 1'b0;
    gs_set   = 1'b0;
    case (state_q)
      S_HALT: if (clr_halt) state_d = S_FETCH;
      S_FETCH: begin
        if (gs_req) begin
          gs_set  = 1'b1;
          state_d = S_HALT;
        end else if (!d_flags[FL_READY]) begin
          state_d = S_HALT;
        end else begin
          ld_en   = 1'b1;
          cnt_d   = '0;
          state_d = (d_len == '0) ? S_RETIRE : S_SEND;
        end
      end
      S_SEND: begin
        if (tx_ready && last_byte) state_d = S_RETIRE;
        else if (tx_ready)         cnt_d = cnt_q + LEN_W'(1);
      end
      S_RETIRE: begin
        desc_clr = 1'b1;
        tx_done  = 1'b1;
        cur_d    = wrap_q ? base_idx : nxt_idx;
        state_d  = S_FETCH;
      end
      default: state_d = S_HALT;
    endcase
    if (load_en) cur_d = load_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HALT;
      cur_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      ptr_q   <= '0;
      crc_q   <= 1'b0;
      irq_q   <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      cnt_q   <= cnt_d;
      if (ld_en) begin
        len_q  <= d_len;
        ptr_q  <= d_ptr;
        crc_q  <= d_flags[FL_CRC];
        irq_q  <= d_flags[FL_IRQ];
        wrap_q <= d_flags[FL_WRAP];
      end
    end
  end

  assign desc_idx = cur_q;
  assign buf_addr = ptr_q + PTR_W'(cnt_q);
  assign tx_valid = (state_q == S_SEND);
  assign tx_sof   = tx_valid && (cnt_q == '0);
  assign tx_eof   = tx_valid && last_byte;
  assign tx_crc   = tx_valid && crc_q;
  assign tx_irq   = tx_valid && irq_q;
  assign halted   = (state_q == S_HALT);
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine import txr_pkg::*; #(
  parameter int NUM_DESC = 8,
  parameter int PTR_W    = 8,
  parameter int LEN_W    = 8,
  parameter int DATA_W   = 8,
  parameter int REG_W    = 16,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int DW      = FLAG_N + LEN_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              desc_we,
  input  logic [IDX_W-1:0]  desc_idx,
  input  logic [DW-1:0]     desc_wdata,
  output logic [DW-1:0]     desc_rdata,
  input  logic              buf_we,
  input  logic [PTR_W-1:0]  buf_addr,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_crc,
  output logic              tx_irq,
  output logic              tx_done
);
  localparam int RDY_POS = PTR_W + LEN_W + FL_READY;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             halted_w, gs_set_w, gs_req_w, gs_done_w;
  logic             clr_halt_w, load_en_w, eng_clr_w;
  logic [IDX_W-1:0] base_w, load_idx_w, eng_idx_w;
  logic [DW-1:0]    eng_word_w;
  logic [PTR_W-1:0] rd_addr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  txr_regs #(.IDX_W(IDX_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halted(halted_w),
    .gs_set(gs_set_w), .base_idx(base_w), .load_en(load_en_w),
    .load_idx(load_idx_w), .clr_halt(clr_halt_w), .gs_req(gs_req_w),
    .gs_done(gs_done_w)
  );

  txr_desc_ram #(.NUM_DESC(NUM_DESC), .DW(DW), .RDY_POS(RDY_POS), .IDX_W(IDX_W)) u_desc (
    .clk(clk), .host_we(desc_we), .host_idx(desc_idx), .host_wdata(desc_wdata),
    .host_rdata(desc_rdata), .eng_idx(eng_idx_w), .eng_clr(eng_clr_w),
    .eng_rdata(eng_word_w)
  );

  txr_buf_ram #(.AW(PTR_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .host_we(buf_we), .host_addr(buf_addr), .host_wdata(buf_wdata),
    .rd_addr(rd_addr_w), .rd_data(tx_data)
  );

  txr_seq #(.NUM_DESC(NUM_DESC), .PTR_W(PTR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .clr_halt(clr_halt_w), .gs_req(gs_req_w),
    .base_idx(base_w), .load_en(load_en_w), .load_idx(load_idx_w),
    .desc_word(eng_word_w), .desc_idx(eng_idx_w), .desc_clr(eng_clr_w),
    .buf_addr(rd_addr_w), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_crc(tx_crc), .tx_irq(tx_irq),
    .tx_done(tx_done), .halted(halted_w), .gs_set(gs_set_w)
  );
endmodule

// File: rtl/txbd_ring_engine_chk.sv
module txbd_ring_engine_chk #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_sof,
  input logic              tx_eof,
  input logic              tx_done,
  input logic              halted,
  input logic              gs_done
);
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_done_no_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_valid);

  assert_eof_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eof |=> !tx_valid);

  assert_parked_until_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !(reg_wr && reg_addr == 2'd1 && reg_wdata[0]) |=> halted);

  assert_stop_parks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gs_done) |-> halted);
endmodule

bind txbd_ring_engine txbd_ring_engine_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_done(tx_done),
  .halted(halted_w), .gs_done(gs_done_w)
);

// File: tb/txbd_ring_engine_bench.sv
module txbd_ring_engine_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] ptr;
    logic [7:0] len;
    logic       crc;
    logic       irq;
    logic [1:0] mode;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'd0,   8'd5,  1'b1, 1'b1, 2'd0},
    '{8'd16,  8'd1,  1'b0, 1'b1, 2'd1},
    '{8'd250, 8'd10, 1'b1, 1'b0, 2'd1},
    '{8'd32,  8'd0,  1'b0, 1'b0, 2'd0},
    '{8'd100, 8'd12, 1'b0, 1'b0, 2'd1},
    '{8'd200, 8'd3,  1'b1, 1'b1, 2'd0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        desc_we = 1'b0;
  logic [2:0]  desc_idx = '0;
  logic [20:0] desc_wdata = '0, desc_rdata;
  logic        buf_we = 1'b0;
  logic [7:0]  buf_addr = '0, buf_wdata = '0;
  logic        tx_valid, tx_ready = 1'b1, tx_sof, tx_eof, tx_crc, tx_irq, tx_done;
  logic [7:0]  tx_data;

  int errors = 0, checks = 0, cyc = 0;
  int rx_n = 0, done_n = 0;
  int rdy_mode = 0;
  logic [7:0] got_d [64];
  logic       got_s [64], got_e [64], got_c [64], got_i [64];

  txbd_ring_engine u_txbd_ring_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_we(desc_we),
    .desc_idx(desc_idx), .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_crc(tx_crc), .tx_irq(tx_irq),
    .tx_done(tx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [20:0] mkd(input logic [7:0] p, input logic [7:0] l,
                                      input logic crc, input logic irq, input logic wrap);
    return {irq, crc, 1'b1, wrap, 1'b1, l, p};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Stream monitor: ready is updated at the falling edge, the transfer is recorded 1 unit later
  always begin
    @(negedge clk);
    if (rdy_mode == 0)      tx_ready = 1'b1;
    else if (rdy_mode == 1) tx_ready = ~tx_ready;
    #1;
    if (tx_valid && tx_ready && rx_n < 64) begin
      got_d[rx_n] = tx_data; got_s[rx_n] = tx_sof; got_e[rx_n] = tx_eof;
      got_c[rx_n] = tx_crc;  got_i[rx_n] = tx_irq;
      rx_n++;
    end
    if (tx_done) done_n++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic desc_write(input int i, input logic [20:0] w);
    @(negedge clk); desc_we = 1'b1; desc_idx = 3'(i); desc_wdata = w;
    @(negedge clk); desc_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic rd_desc(input int i, output logic [20:0] v);
    desc_idx = 3'(i); #1; v = desc_rdata;
  endtask

  task automatic wait_park();
    logic [15:0] r;
    int n = 0;
    do begin
      @(negedge clk); rd_reg(2'd2, r); n++;
    end while (!r[0] && n < 3000);
    chk(r[0], "R8", "engine parks on a descriptor that is not ready", int'(r[0]), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_bytes(input string req, input int p, input int l, input int base_k);
    int bad = 0;
    for (int k = 0; k < l; k++)
      if (got_d[base_k + k] !== pat((p + k) % 256)) bad++;
    chk(bad == 0, req, "byte values from buffer store", bad, 0);
  endtask

  initial begin
    logic [15:0] r;
    logic [20:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    rd_reg(2'd2, r);
    chk(r[1:0] == 2'b01, "R1", "event register after reset", int'(r[1:0]), 1);
    chk(!tx_valid, "R1", "tx_valid after reset", int'(tx_valid), 0);
    chk(!tx_done, "R1", "tx_done after reset", int'(tx_done), 0);

    for (int a = 0; a < 256; a++) begin
      @(negedge clk); buf_we = 1'b1; buf_addr = 8'(a); buf_wdata = pat(a);
    end
    @(negedge clk); buf_we = 1'b0;
    for (int i = 0; i < 8; i++) desc_write(i, '0);

    // R2: a ready descriptor is ignored until clear-halt
    rx_n = 0;
    desc_write(0, mkd(8'd0, 8'd5, 1'b1, 1'b1, 1'b0));
    repeat (20) @(negedge clk);
    chk(rx_n == 0, "R2", "bytes sent before clear-halt", rx_n, 0);
    rd_desc(0, w);
    chk(w[16], "R2", "descriptor ready bit before clear-halt", int'(w[16]), 1);

    // Table-driven descriptors, one per slot starting at slot 0
    for (int v = 0; v < 6; v++) begin
      int bad_m = 0, bad_f = 0;
      desc_write(v, mkd(VEC[v].ptr, VEC[v].len, VEC[v].crc, VEC[v].irq, 1'b0));
      rdy_mode = int'(VEC[v].mode);
      rx_n = 0; done_n = 0;
      reg_write(2'd1, 16'h0001);
      wait_park();
      chk(rx_n == int'(VEC[v].len), "R3", "byte count", rx_n, int'(VEC[v].len));
      check_bytes("R3", int'(VEC[v].ptr), int'(VEC[v].len), 0);
      for (int k = 0; k < rx_n; k++) begin
        if (got_s[k] !== (k == 0) || got_e[k] !== (k == int'(VEC[v].len) - 1)) bad_m++;
        if (got_c[k] !== VEC[v].crc || got_i[k] !== VEC[v].irq) bad_f++;
      end
      chk(bad_m == 0, "R4", "start/end markers", bad_m, 0);
      chk(bad_f == 0, "R5", "sideband flags", bad_f, 0);
      chk(done_n == 1, "R6", "done pulses", done_n, 1);
      rd_desc(v, w);
      chk(!w[16], "R6", "ready bit after completion", int'(w[16]), 0);
    end

    // R10 + R7: base load and wrap back to base
    rdy_mode = 0;
    reg_write(2'd0, 16'd2);
    rd_reg(2'd0, r);
    chk(r[2:0] == 3'd2, "R10", "ring base readback", int'(r[2:0]), 2);
    desc_write(2, mkd(8'd0, 8'd3, 1'b0, 1'b0, 1'b0));
    desc_write(3, mkd(8'd20, 8'd2, 1'b0, 1'b0, 1'b1));
    desc_write(4, mkd(8'd40, 8'd4, 1'b0, 1'b0, 1'b0));
    rx_n = 0; done_n = 0;
    reg_write(2'd1, 16'h0001);
    wait_park();
    chk(rx_n == 5, "R10", "bytes sent starting at loaded slot", rx_n, 5);
    check_bytes("R10", 0, 3, 0);
    check_bytes("R7", 20, 2, 3);
    chk(done_n == 2, "R7", "done pulses before wrap", done_n, 2);
    rd_desc(4, w);
    chk(w[16], "R7", "slot after wrap descriptor untouched", int'(w[16]), 1);

    // R8: resume at the slot that parked the engine (the base slot)
    desc_write(2, mkd(8'd60, 8'd1, 1'b0, 1'b0, 1'b0));
    rx_n = 0;
    reg_write(2'd1, 16'h0001);
    wait_park();
    chk(rx_n == 1 && got_d[0] == pat(60), "R8", "resume sends the parked slot", int'(got_d[0]), int'(pat(60)));

    // R9: stop request in the same cycle as the last byte is accepted
    desc_write(3, mkd(8'd80, 8'd1, 1'b0, 1'b0, 1'b0));
    rdy_mode = 3; tx_ready = 1'b0;
    rx_n = 0; done_n = 0;
    reg_write(2'd1, 16'h0001);
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!(tx_valid && tx_eof) && n < 200);
    end
    tx_ready = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0002;
    @(negedge clk); reg_wr = 1'b0; tx_ready = 1'b0;
    repeat (6) @(negedge clk);
    chk(rx_n == 1 && got_d[0] == pat(80), "R9", "in-flight frame finished", rx_n, 1);
    chk(done_n == 1, "R9", "done pulses with stop", done_n, 1);
    rd_reg(2'd2, r);
    chk(r[1:0] == 2'b11, "R9", "event bits after stop", int'(r[1:0]), 3);
    rd_desc(4, w);
    chk(w[16], "R9", "next ready slot not fetched", int'(w[16]), 1);
    reg_write(2'd2, 16'h0002);
    rd_reg(2'd2, r);
    chk(!r[1], "R9", "stop-complete cleared by write-one", int'(r[1]), 0);
    reg_write(2'd1, 16'h0000);

    // R8: resume after the stop, continuing at the next slot
    rdy_mode = 0; rx_n = 0;
    reg_write(2'd1, 16'h0001);
    wait_park();
    chk(rx_n == 4, "R8", "bytes after resume", rx_n, 4);
    check_bytes("R8", 40, 4, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule